// File: doc/BRIEF.md
# Tunable PTP Real-Time Clock

This block keeps time of day in the PTP layout: a 48-bit seconds count, a 32-bit nanoseconds count and an 8-bit sub-nanosecond fraction. On every cycle of its reference clock it adds a programmable step to that time. The step has 8 integer and 32 fractional nanosecond bits, and the extra 24 fractional bits are kept in a hidden residue. Because of this residue, tuning the step tunes the frequency of the clock. The current time is driven as a parallel bus for other logic in the same domain. A pulse-per-second strobe marks each seconds rollover.

Software reaches the block from its own clock domain through a single command port. A command can set the time, set the step, start a timed offset, or take a snapshot of the time. The offset adds a signed amount to the step for a set number of cycles and then stops. Each command is held stable in the software domain, flagged to the clock domain by a toggle, and acknowledged back by a second toggle. Snapshot results are loaded into software-domain registers when that acknowledge arrives.

Top module: `ptp_rtc`

## Requirements
- R1: While `rst` is high, `tod_sec`, `tod_ns`, `tod_frac` and `pps` are zero. `cmd_busy` is low while `sw_rst` is high. After reset the step is `PERIOD_RST` (default 4 ns), so k cycles after `rst` falls the time reads k*4 ns.
- R2: Each cycle, {ns, fraction} advances by the step. Step bits [39:32] are whole ns and bits [31:0] are a binary fraction of 2^-32 ns. Only the top 8 fraction bits appear on `tod_frac`, in units of 2^-8 ns, and the rest carry over between cycles.
- R3: When the advanced nanosecond value is 1,000,000,000 or more, 1,000,000,000 is subtracted and seconds increase by one in the same cycle. `tod_ns` never shows a value of 10^9 or more.
- R4: `pps` rises in the cycle in which a rollover raises seconds. It stays high for exactly `PPS_CYCLES` cycles and is low otherwise.
- R5: Op 2'b01 (set time) loads `cmd_sec`, `cmd_ns` and `cmd_frac` into the time and clears the hidden residue. It takes precedence over that cycle's increment.
- R6: Op 2'b10 (set step) loads `cmd_period`. The new step applies from the following cycle.
- R7: Op 2'b11 (offset) applies to the next `cmd_adj_len` cycles. In each of them, `cmd_adj_ofs` (two's complement, units of 2^-8 ns) is added to the step. A resulting step below zero is taken as zero. Afterwards the plain step is used again, and a length of 0 adds nothing.
- R8: Op 2'b00 (read) captures seconds, ns and fraction together in one clock-domain cycle between request and acknowledge. The capture is presented on `rd_sec`, `rd_ns` and `rd_frac` when `cmd_done` pulses.
- R9: `cmd_valid` is taken only while `cmd_busy` is low. `cmd_busy` then stays high until the one-cycle `cmd_done` pulse, and any `cmd_valid` seen while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the time counter |
| rst | input | 1 | Synchronous active-high reset, clock domain |
| sw_clk | input | 1 | Software-side clock |
| sw_rst | input | 1 | Synchronous active-high reset, software domain |
| cmd_valid | input | 1 | Command strobe, software domain |
| cmd_op | input | 2 | 00 read, 01 set time, 10 set step, 11 offset |
| cmd_sec | input | 48 | Seconds for set time |
| cmd_ns | input | 32 | Nanoseconds for set time |
| cmd_frac | input | 8 | 2^-8 ns fraction for set time |
| cmd_period | input | 40 | Step, 8.32 fixed-point ns |
| cmd_adj_ofs | input | 32 | Signed offset per cycle, 2^-8 ns units |
| cmd_adj_len | input | 32 | Offset duration in clock cycles |
| cmd_busy | output | 1 | Command in flight |
| cmd_done | output | 1 | One-cycle completion pulse |
| rd_sec | output | 48 | Snapshot seconds |
| rd_ns | output | 32 | Snapshot nanoseconds |
| rd_frac | output | 8 | Snapshot fraction |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 32 | Live nanoseconds |
| tod_frac | output | 8 | Live 2^-8 ns fraction |
| pps | output | 1 | Pulse per second |

## Verification
The hardest effect to see from the ports is the hidden 24-bit residue. It shows up only as a single 2^-8 ns carry after thousands of cycles, and its starting value is unknown once earlier steps have run. The bench measures time differences over exact cycle windows. It picks step and window pairs whose product is a whole multiple of 2^-8 ns, so the expected difference is exact whatever the residue was. Timed offsets begin at a cycle that depends on the handshake, so each offset window is made long enough to contain the entire offset.

// File: rtl/ptp_rtc_pkg.sv
package ptp_rtc_pkg;
  localparam int SEC_W   = 48;
  localparam int NS_W    = 32;
  localparam int FRAC_W  = 8;
  localparam int PINT_W  = 8;
  localparam int PFRAC_W = 32;
  localparam int PER_W   = PINT_W + PFRAC_W;
  localparam int OFS_W   = 32;
  localparam int LEN_W   = 32;
  localparam logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

  typedef enum logic [1:0] {
    OP_READ       = 2'b00,
    OP_SET_TIME   = 2'b01,
    OP_SET_PERIOD = 2'b10,
    OP_ADJUST     = 2'b11
  } rtc_op_e;
endpackage

// File: rtl/ptp_rtc_xfer.sv
module ptp_rtc_xfer import ptp_rtc_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_clk,
  input  logic              sw_rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEC_W-1:0]  cmd_sec,
  input  logic [NS_W-1:0]   cmd_ns,
  input  logic [FRAC_W-1:0] cmd_frac,
  input  logic [PER_W-1:0]  cmd_period,
  input  logic [OFS_W-1:0]  cmd_adj_ofs,
  input  logic [LEN_W-1:0]  cmd_adj_len,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic [SEC_W-1:0]  rd_sec,
  output logic [NS_W-1:0]   rd_ns,
  output logic [FRAC_W-1:0] rd_frac,
  output logic              fire,
  output logic [1:0]        h_op,
  output logic [SEC_W-1:0]  h_sec,
  output logic [NS_W-1:0]   h_ns,
  output logic [FRAC_W-1:0] h_frac,
  output logic [PER_W-1:0]  h_period,
  output logic [OFS_W-1:0]  h_ofs,
  output logic [LEN_W-1:0]  h_len,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [NS_W-1:0]   tod_ns,
  input  logic [FRAC_W-1:0] tod_frac
);
  localparam int MSB = SYNC_STAGES - 1;

  logic                   req_tgl, ack_tgl, busy_q, done_q;
  logic [SYNC_STAGES-1:0] req_sync, ack_sync;
  logic                   req_prev, ack_prev, ack_edge;
  logic [SEC_W-1:0]       snap_sec;
  logic [NS_W-1:0]        snap_ns;
  logic [FRAC_W-1:0]      snap_frac;

  // software side: hold command, toggle request, collect acknowledge
  assign ack_edge = ack_sync[MSB] ^ ack_prev;

  always_ff @(posedge sw_clk) begin
    if (sw_rst) begin
      req_tgl  <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ack_sync <= '0;
      ack_prev <= 1'b0;
      h_op     <= '0;
      h_sec    <= '0;
      h_ns     <= '0;
      h_frac   <= '0;
      h_period <= '0;
      h_ofs    <= '0;
      h_len    <= '0;
      rd_sec   <= '0;
      rd_ns    <= '0;
      rd_frac  <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_STAGES-2:0], ack_tgl};
      ack_prev <= ack_sync[MSB];
      done_q   <= 1'b0;
      if (ack_edge) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (h_op == OP_READ) begin
          rd_sec  <= snap_sec;
          rd_ns   <= snap_ns;
          rd_frac <= snap_frac;
        end
      end else if (cmd_valid && !busy_q) begin
        h_op     <= cmd_op;
        h_sec    <= cmd_sec;
        h_ns     <= cmd_ns;
        h_frac   <= cmd_frac;
        h_period <= cmd_period;
        h_ofs    <= cmd_adj_ofs;
        h_len    <= cmd_adj_len;
        req_tgl  <= ~req_tgl;
        busy_q   <= 1'b1;
      end
    end
  end

  assign cmd_busy = busy_q;
  assign cmd_done = done_q;

  // clock side: detect request, capture snapshot, return acknowledge
  assign fire = req_sync[MSB] ^ req_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_sync  <= '0;
      req_prev  <= 1'b0;
      ack_tgl   <= 1'b0;
      snap_sec  <= '0;
      snap_ns   <= '0;
      snap_frac <= '0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-2:0], req_tgl};
      req_prev <= req_sync[MSB];
      if (fire) begin
        ack_tgl <= ~ack_tgl;
        if (h_op == OP_READ) begin
          snap_sec  <= tod_sec;
          snap_ns   <= tod_ns;
          snap_frac <= tod_frac;
        end
      end
    end
  end

  // R9: held command stays frozen while a transfer is in flight
  p_hold_stable_r9: assert property (@(posedge sw_clk) disable iff (sw_rst)
    busy_q |=> ($stable(h_op) && $stable(h_period) && $stable(h_sec) && $stable(h_len)));
  // R9: completion is a single-cycle pulse with busy released
  p_done_pulse_r9: assert property (@(posedge sw_clk) disable iff (sw_rst)
    done_q |-> (!busy_q ##1 !done_q));
endmodule

// File: rtl/ptp_rtc_core.sv
module ptp_rtc_core import ptp_rtc_pkg::*; #(
  parameter logic [PER_W-1:0] PERIOD_RST = 40'h04_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [1:0]        op,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic [NS_W-1:0]   set_ns,
  input  logic [FRAC_W-1:0] set_frac,
  input  logic [PER_W-1:0]  set_period,
  input  logic [OFS_W-1:0]  set_ofs,
  input  logic [LEN_W-1:0]  set_len,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [FRAC_W-1:0] tod_frac,
  output logic              sec_tick
);
  localparam int ACC_W  = NS_W + PFRAC_W;
  localparam int SUB_W  = PFRAC_W - FRAC_W;
  localparam int STEP_W = ACC_W + 2;

  logic [SEC_W-1:0]         sec_q;
  logic [ACC_W-1:0]         acc_q;
  logic [PER_W-1:0]         period_q;
  logic [OFS_W-1:0]         ofs_q;
  logic [LEN_W-1:0]         len_q;
  logic signed [STEP_W-1:0] step_s, ofs_ext;
  logic [ACC_W:0]           step_u, sum;
  logic [NS_W:0]            ns_sum, ns_next;
  logic                     wrap, ld_time, ld_adj;

  assign ld_time = fire && (op == OP_SET_TIME);
  assign ld_adj  = fire && (op == OP_ADJUST);

  always_comb begin
    ofs_ext = {{(STEP_W-OFS_W){ofs_q[OFS_W-1]}}, ofs_q};
    step_s  = $signed({{(STEP_W-PER_W){1'b0}}, period_q});
    if (len_q != '0) step_s = step_s + (ofs_ext <<< SUB_W);
    step_u  = step_s[STEP_W-1] ? '0 : step_s[ACC_W:0];
    sum     = {1'b0, acc_q} + step_u;
    ns_sum  = sum[ACC_W:PFRAC_W];
    wrap    = ns_sum >= {1'b0, NS_PER_SEC};
    ns_next = wrap ? (ns_sum - {1'b0, NS_PER_SEC}) : ns_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '0;
      acc_q    <= '0;
      period_q <= PERIOD_RST;
      ofs_q    <= '0;
      len_q    <= '0;
    end else begin
      if (ld_time) begin
        sec_q <= set_sec;
        acc_q <= {set_ns, set_frac, {SUB_W{1'b0}}};
      end else begin
        acc_q <= {ns_next[NS_W-1:0], sum[PFRAC_W-1:0]};
        if (wrap) sec_q <= sec_q + 1'b1;
      end
      if (fire && (op == OP_SET_PERIOD)) period_q <= set_period;
      if (ld_adj) begin
        ofs_q <= set_ofs;
        len_q <= set_len;
      end else if (len_q != '0) begin
        len_q <= len_q - 1'b1;
      end
    end
  end

  assign sec_tick = wrap && !ld_time;
  assign tod_sec  = sec_q;
  assign tod_ns   = acc_q[ACC_W-1:PFRAC_W];
  assign tod_frac = acc_q[PFRAC_W-1:SUB_W];

  // R3: nanoseconds stay below one second
  p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
    (tod_ns < NS_PER_SEC) && !ns_next[NS_W]);
  // R3: seconds only hold or step by one unless loaded
  p_sec_step_r3: assert property (@(posedge clk) disable iff (rst)
    !ld_time |=> (sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1));
  // R5: a time load lands exactly and clears the residue
  p_load_time_r5: assert property (@(posedge clk) disable iff (rst)
    ld_time |=> (sec_q == $past(set_sec)) && (acc_q[SUB_W-1:0] == '0));
  // R7: the offset duration counts down one per cycle
  p_adj_count_r7: assert property (@(posedge clk) disable iff (rst)
    ((len_q != '0) && !ld_adj) |=> (len_q == $past(len_q) - 1'b1));
endmodule

// File: rtl/ptp_rtc_pps.sv
module ptp_rtc_pps #(
  parameter int PPS_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  output logic pps
);
  localparam int CNT_W = (PPS_CYCLES > 1) ? $clog2(PPS_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             pps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_q <= 1'b0;
      cnt_q <= '0;
    end else if (sec_tick) begin
      pps_q <= 1'b1;
      cnt_q <= CNT_W'(PPS_CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      pps_q <= 1'b0;
    end
  end

  assign pps = pps_q;

  // R4: a rollover raises the pulse on the next visible cycle
  p_pps_start_r4: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> pps_q);
  // R4: without a rollover the pulse never starts
  p_pps_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!pps_q && !sec_tick) |=> !pps_q);
endmodule

// File: rtl/ptp_rtc.sv
module ptp_rtc import ptp_rtc_pkg::*; #(
  parameter logic [PER_W-1:0] PERIOD_RST  = 40'h04_0000_0000,
  parameter int               PPS_CYCLES  = 10,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_clk,
  input  logic              sw_rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEC_W-1:0]  cmd_sec,
  input  logic [NS_W-1:0]   cmd_ns,
  input  logic [FRAC_W-1:0] cmd_frac,
  input  logic [PER_W-1:0]  cmd_period,
  input  logic [OFS_W-1:0]  cmd_adj_ofs,
  input  logic [LEN_W-1:0]  cmd_adj_len,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic [SEC_W-1:0]  rd_sec,
  output logic [NS_W-1:0]   rd_ns,
  output logic [FRAC_W-1:0] rd_frac,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [FRAC_W-1:0] tod_frac,
  output logic              pps
);
  logic              fire, sec_tick;
  logic [1:0]        h_op;
  logic [SEC_W-1:0]  h_sec;
  logic [NS_W-1:0]   h_ns;
  logic [FRAC_W-1:0] h_frac;
  logic [PER_W-1:0]  h_period;
  logic [OFS_W-1:0]  h_ofs;
  logic [LEN_W-1:0]  h_len;

  ptp_rtc_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk(clk), .rst(rst), .sw_clk(sw_clk), .sw_rst(sw_rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sec(cmd_sec), .cmd_ns(cmd_ns),
    .cmd_frac(cmd_frac), .cmd_period(cmd_period), .cmd_adj_ofs(cmd_adj_ofs),
    .cmd_adj_len(cmd_adj_len), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .rd_sec(rd_sec), .rd_ns(rd_ns), .rd_frac(rd_frac),
    .fire(fire), .h_op(h_op), .h_sec(h_sec), .h_ns(h_ns), .h_frac(h_frac),
    .h_period(h_period), .h_ofs(h_ofs), .h_len(h_len),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
  );

  ptp_rtc_core #(.PERIOD_RST(PERIOD_RST)) u_core (
    .clk(clk), .rst(rst), .fire(fire), .op(h_op),
    .set_sec(h_sec), .set_ns(h_ns), .set_frac(h_frac), .set_period(h_period),
    .set_ofs(h_ofs), .set_len(h_len),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac), .sec_tick(sec_tick)
  );

  ptp_rtc_pps #(.PPS_CYCLES(PPS_CYCLES)) u_pps (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .pps(pps)
  );
endmodule

// File: tb/ptp_rtc_tb.sv
`timescale 1ns/1ps
module ptp_rtc_tb;
  localparam int PPS_N = 10;
  // {step 40, offset 32, length 32, window 32}
  localparam logic [135:0] VEC [7] = '{
    {40'h04_0000_0000, 32'h0000_0000, 32'd0,   32'd64},
    {40'h04_8000_0000, 32'h0000_0000, 32'd0,   32'd64},
    {40'h04_0000_1000, 32'h0000_0000, 32'd0,   32'd4096},
    {40'h04_0000_0000, 32'h0000_0100, 32'd100, 32'd400},
    {40'h04_0000_0000, 32'hFFFF_FD80, 32'd40,  32'd300},
    {40'h04_0000_0000, 32'hFFFF_F800, 32'd10,  32'd300},
    {40'h07_4000_0000, 32'h0000_0040, 32'd64,  32'd512}
  };

  logic clk = 0, sw_clk = 0, rst = 1, sw_rst = 1;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [47:0] cmd_sec = 0;
  logic [31:0] cmd_ns = 0;
  logic [7:0] cmd_frac = 0;
  logic [39:0] cmd_period = 0;
  logic [31:0] cmd_adj_ofs = 0, cmd_adj_len = 0;
  logic cmd_busy, cmd_done, pps;
  logic [47:0] rd_sec, tod_sec;
  logic [31:0] rd_ns, tod_ns;
  logic [7:0] rd_frac, tod_frac;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;
  always #5 sw_clk = ~sw_clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptp_rtc #(.PPS_CYCLES(PPS_N)) u_dut (
    .clk(clk), .rst(rst), .sw_clk(sw_clk), .sw_rst(sw_rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sec(cmd_sec), .cmd_ns(cmd_ns),
    .cmd_frac(cmd_frac), .cmd_period(cmd_period), .cmd_adj_ofs(cmd_adj_ofs),
    .cmd_adj_len(cmd_adj_len), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .rd_sec(rd_sec), .rd_ns(rd_ns), .rd_frac(rd_frac),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac), .pps(pps)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lin(input logic [47:0] s, input logic [31:0] n, input logic [7:0] f);
    return longint'(s) * 64'd256_000_000_000 + longint'(n) * 256 + longint'(f);
  endfunction

  task automatic issue(input logic [1:0] op, input logic [47:0] s, input logic [31:0] n,
                       input logic [7:0] f, input logic [39:0] p,
                       input logic [31:0] o, input logic [31:0] l);
    @(negedge sw_clk);
    while (cmd_busy) @(negedge sw_clk);
    cmd_op = op; cmd_sec = s; cmd_ns = n; cmd_frac = f;
    cmd_period = p; cmd_adj_ofs = o; cmd_adj_len = l; cmd_valid = 1;
    @(negedge sw_clk);
    cmd_valid = 0;
    while (!cmd_done) @(negedge sw_clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint t1, t2, r, expd, st, pv;
    int c1, k;
    logic [31:0] prev_ns;
    logic prev_pps;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(tod_sec == 0 && tod_ns == 0 && tod_frac == 0, "R1 time", lin(tod_sec, tod_ns, tod_frac), 0);
    chk(pps == 0, "R1 pps", pps, 0);
    chk(cmd_busy == 0 && cmd_done == 0, "R1 busy", cmd_busy, 0);
    @(negedge sw_clk); sw_rst = 0;
    @(negedge clk); rst = 0;
    repeat (16) @(negedge clk);
    chk(lin(tod_sec, tod_ns, tod_frac) == 16 * 1024, "R1 reset step",
        lin(tod_sec, tod_ns, tod_frac), 16 * 1024);

    // table: step and offset vectors measured over exact windows
    for (int i = 0; i < 7; i++) begin
      logic [39:0] p; logic [31:0] o, l, w;
      string req;
      {p, o, l, w} = VEC[i];
      issue(2'b10, 0, 0, 0, p, 0, 0);
      @(negedge clk); c1 = cyc; t1 = lin(tod_sec, tod_ns, tod_frac);
      if (l != 0) issue(2'b11, 0, 0, 0, 0, o, l);
      while (cyc != c1 + int'(w)) @(negedge clk);
      t2 = lin(tod_sec, tod_ns, tod_frac);
      st = longint'(p) + (longint'($signed(o)) <<< 24);
      if (st < 0) st = 0;
      expd = ((longint'(w) - longint'(l)) * longint'(p) + longint'(l) * st) >>> 24;
      req = (l != 0) ? "R7 offset" : ((i == 0 || i == 2) ? "R2 step" : "R6 step");
      chk(t2 - t1 == expd, req, t2 - t1, expd);
    end

    // R9: a second command while busy is dropped
    @(negedge sw_clk);
    cmd_op = 2'b10; cmd_period = 40'h09_0000_0000; cmd_valid = 1;
    @(negedge sw_clk);
    chk(cmd_busy == 1, "R9 busy", cmd_busy, 1);
    cmd_period = 40'h02_0000_0000;
    @(negedge sw_clk);
    cmd_valid = 0;
    while (!cmd_done) @(negedge sw_clk);
    @(negedge clk); c1 = cyc; t1 = lin(tod_sec, tod_ns, tod_frac);
    while (cyc != c1 + 64) @(negedge clk);
    t2 = lin(tod_sec, tod_ns, tod_frac);
    chk(t2 - t1 == 64 * 9 * 256, "R9 drop", t2 - t1, 64 * 9 * 256);

    // R5: set time near a rollover
    issue(2'b10, 0, 0, 0, 40'h04_0000_0000, 0, 0);
    @(negedge clk); c1 = cyc;
    issue(2'b01, 48'd5, 32'd999_999_000, 8'h40, 0, 0, 0);
    @(negedge clk);
    t1 = lin(48'd5, 32'd999_999_000, 8'h40);
    t2 = lin(tod_sec, tod_ns, tod_frac);
    chk(t2 >= t1 && t2 - t1 <= longint'(cyc - c1) * 1024, "R5 load", t2, t1);
    chk(tod_frac == 8'h40, "R5 residue", tod_frac, 8'h40);

    // R3 / R4: rollover and pulse
    prev_ns = tod_ns; prev_pps = pps;
    k = 0;
    while (tod_sec == 5 && k < 2000) begin
      prev_ns = tod_ns; prev_pps = pps;
      @(negedge clk); k++;
    end
    chk(tod_sec == 6, "R3 sec", tod_sec, 6);
    pv = longint'(prev_ns) + 4 - 1_000_000_000;
    chk(longint'(tod_ns) == pv, "R3 ns wrap", tod_ns, pv);
    chk(pps == 1 && prev_pps == 0, "R4 rise", pps, 1);
    k = 0;
    while (pps && k < 100) begin k++; @(negedge clk); end
    chk(k == PPS_N, "R4 width", k, PPS_N);

    // R8: coherent snapshot between request and completion
    @(negedge clk); t1 = lin(tod_sec, tod_ns, tod_frac);
    issue(2'b00, 0, 0, 0, 0, 0, 0);
    @(negedge clk); t2 = lin(tod_sec, tod_ns, tod_frac);
    r = lin(rd_sec, rd_ns, rd_frac);
    chk(r >= t1 && r <= t2, "R8 snapshot", r, t1);
    chk(rd_sec == 6, "R8 seconds", rd_sec, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule